// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block produces the serial clock of an I2C master from a fast system clock. It never drives the line high. It asks for SCL to be pulled low during the low phase. It then releases the line and waits until the sampled SCL level reads high before it starts timing the high phase. A slave that holds the line low therefore stretches the clock for as long as it needs to.

The phase lengths come from one divider count, scaled by a ratio. Standard mode uses 1:1. Fast mode uses 2:1 or 16:9 (low:high), picked by a duty select. The count is raised to a floor for each mode. A rise-time count, meaning the worst-case SCL rise time in system clocks plus one, is subtracted from the timed high phase. This keeps the real bus period close to the programmed period even though the line takes time to rise. A byte or bit sequencer uses the one-cycle phase-start pulses to place data changes and samples.

Top module: `scl_clkgen`

## Requirements
- R1: With `fast_mode`=0, the low phase (cycles with `scl_drive_low`=1) lasts `clk_div_count` cycles, and the timed high phase lasts `clk_div_count` minus the rise credit.
- R2: With `fast_mode`=1 and `duty_16_9`=0, the low phase lasts 2×count cycles and the untrimmed high phase lasts 1×count.
- R3: With `fast_mode`=1 and `duty_16_9`=1, the low phase lasts 16×count cycles and the untrimmed high phase lasts 9×count.
- R4: In standard mode, a count below 4 acts as 4.
- R5: In fast mode, a count of 0 acts as 1.
- R6: The timed high phase, measured from `high_start` to the next `low_start`, equals the untrimmed high length minus `rise_count`. It is never shorter than 1 cycle.
- R7: After SCL is released, `high_start` comes one cycle after the first cycle in which `scl_in` is sampled high. While `scl_in` stays low, the line stays released and no `high_start` occurs.
- R8: While `run_en`=0, from the next cycle on, `scl_drive_low`, `low_start` and `high_start` are all 0. When `run_en` returns to 1, the next cycle begins a full low phase and asserts `low_start`.
- R9: `low_start` and `high_start` are each one cycle wide and never asserted together. `low_start` is asserted in the first cycle of every low phase.
- R10: After synchronous reset, `scl_drive_low`, `low_start` and `high_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables clock generation; 0 releases SCL and clears the state |
| clk_div_count | input | CNT_W (12) | Divider count scaling both phases |
| fast_mode | input | 1 | 0 = standard (1:1), 1 = fast |
| duty_16_9 | input | 1 | Fast mode only: 0 = 2:1, 1 = 16:9 low:high |
| rise_count | input | RISE_W (6) | Worst-case rise time in system clocks plus one |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| high_start | output | 1 | One-cycle pulse in the first cycle of the timed high phase |
| low_start | output | 1 | One-cycle pulse in the first cycle of the low phase |

## Verification
A wrong phase state shows up directly on `scl_drive_low` or on a missing or misplaced phase pulse, within one SCL period. A wrong length or clamp result shows up as a measurable change in the low-phase width or in the `high_start`-to-`low_start` spacing, within the period after the configuration is applied. A fault in the wait-for-high logic appears as a `high_start` during a held-low stretch, or as a long stall after the line is freed. A fault in the enable path shows up one cycle after `run_en` changes.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

    localparam int unsigned DEF_CNT_W      = 12;
    localparam int unsigned DEF_RISE_W     = 6;
    localparam int unsigned STD_MIN_COUNT  = 4;
    localparam int unsigned FAST_MIN_COUNT = 1;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        RATIO_1_1  = 2'd0,
        RATIO_2_1  = 2'd1,
        RATIO_16_9 = 2'd2
    } ratio_t;

    typedef struct packed {
        logic clear;
        logic load;
        logic inc;
    } timer_ctl_t;

    function automatic ratio_t pick_ratio(input logic fast, input logic duty);
        if (!fast)     return RATIO_1_1;
        else if (duty) return RATIO_16_9;
        else           return RATIO_2_1;
    endfunction

endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
    import scl_clkgen_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned RISE_W = DEF_RISE_W,
    parameter int unsigned LEN_W  = CNT_W + 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count,
    input  logic              fast,
    input  logic              duty,
    input  logic [RISE_W-1:0] rise,
    output logic [LEN_W-1:0]  low_len,
    output logic [LEN_W-1:0]  high_len
);

    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] high_raw;
    logic [LEN_W-1:0] rise_ext;
    ratio_t           ratio;

    // Per-mode floor on the divider count.
    always_comb begin
        if (!fast) begin
            base = (count < CNT_W'(STD_MIN_COUNT)) ? LEN_W'(STD_MIN_COUNT) : LEN_W'(count);
        end else begin
            base = (count < CNT_W'(FAST_MIN_COUNT)) ? LEN_W'(FAST_MIN_COUNT) : LEN_W'(count);
        end
    end

    // Ratio scaling done with shifts and one add.
    always_comb begin
        ratio = pick_ratio(fast, duty);
        unique case (ratio)
            RATIO_2_1: begin
                low_len  = base << 1;
                high_raw = base;
            end
            RATIO_16_9: begin
                low_len  = base << 4;
                high_raw = (base << 3) + base;
            end
            default: begin
                low_len  = base;
                high_raw = base;
            end
        endcase
    end

    // Rise-time credit, floored at one cycle.
    assign rise_ext = LEN_W'(rise);
    assign high_len = (high_raw > rise_ext) ? (high_raw - rise_ext) : LEN_W'(1);

    assert_high_floor_R6: assert property (@(posedge clk) disable iff (rst)
        high_len != '0);

    assert_std_floor_R4: assert property (@(posedge clk) disable iff (rst)
        !fast |-> (low_len >= LEN_W'(STD_MIN_COUNT)));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_clkgen_pkg::*;
#(
    parameter int unsigned LEN_W = DEF_CNT_W + 5
) (
    input  logic             clk,
    input  logic             rst,
    input  timer_ctl_t       ctl,
    input  logic [LEN_W-1:0] target,
    output logic             at_end
);

    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            cnt_q <= '0;
        end else if (ctl.load) begin
            cnt_q <= LEN_W'(1);
        end else if (ctl.inc) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign at_end = (cnt_q >= target);

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        ctl.inc |-> (cnt_q != '1));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       scl_in,
    input  logic       at_end,
    output timer_ctl_t tctl,
    output logic       sel_high,
    output logic       scl_drive_low,
    output logic       high_start,
    output logic       low_start
);

    phase_t state_q, state_d;
    logic   low_pulse_d, high_pulse_d;
    logic   low_start_q, high_start_q;

    always_comb begin
        state_d      = state_q;
        tctl         = '0;
        low_pulse_d  = 1'b0;
        high_pulse_d = 1'b0;
        if (!run_en) begin
            state_d    = PH_IDLE;
            tctl.clear = 1'b1;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d     = PH_LOW;
                    tctl.load   = 1'b1;
                    low_pulse_d = 1'b1;
                end
                PH_LOW: begin
                    if (at_end) begin
                        state_d    = PH_WAIT_HI;
                        tctl.clear = 1'b1;
                    end else begin
                        tctl.inc = 1'b1;
                    end
                end
                PH_WAIT_HI: begin
                    if (scl_in) begin
                        state_d      = PH_HIGH;
                        tctl.load    = 1'b1;
                        high_pulse_d = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (at_end) begin
                        state_d     = PH_LOW;
                        tctl.load   = 1'b1;
                        low_pulse_d = 1'b1;
                    end else begin
                        tctl.inc = 1'b1;
                    end
                end
                default: begin
                    state_d    = PH_IDLE;
                    tctl.clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= PH_IDLE;
            low_start_q  <= 1'b0;
            high_start_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            low_start_q  <= low_pulse_d;
            high_start_q <= high_pulse_d;
        end
    end

    assign sel_high      = (state_q == PH_HIGH);
    assign scl_drive_low = (state_q == PH_LOW);
    assign low_start     = low_start_q;
    assign high_start    = high_start_q;

    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(low_start && high_start));

    assert_low_start_drive_R9: assert property (@(posedge clk) disable iff (rst)
        low_start |-> scl_drive_low);

    assert_rise_has_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> low_start);

    assert_high_after_line_R7: assert property (@(posedge clk) disable iff (rst)
        high_start |-> (!scl_drive_low && $past(scl_in)));

    assert_idle_release_R8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!scl_drive_low && !low_start && !high_start));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned RISE_W = DEF_RISE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [CNT_W-1:0]  clk_div_count,
    input  logic              fast_mode,
    input  logic              duty_16_9,
    input  logic [RISE_W-1:0] rise_count,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              high_start,
    output logic              low_start
);

    localparam int unsigned LEN_W = CNT_W + 5;

    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic [LEN_W-1:0] target;
    logic             at_end;
    logic             sel_high;
    timer_ctl_t       tctl;

    scl_phase_calc #(
        .CNT_W  (CNT_W),
        .RISE_W (RISE_W),
        .LEN_W  (LEN_W)
    ) u_calc (
        .clk      (clk),
        .rst      (rst),
        .count    (clk_div_count),
        .fast     (fast_mode),
        .duty     (duty_16_9),
        .rise     (rise_count),
        .low_len  (low_len),
        .high_len (high_len)
    );

    assign target = sel_high ? high_len : low_len;

    scl_phase_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .ctl    (tctl),
        .target (target),
        .at_end (at_end)
    );

    scl_phase_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .run_en        (run_en),
        .scl_in        (scl_in),
        .at_end        (at_end),
        .tctl          (tctl),
        .sel_high      (sel_high),
        .scl_drive_low (scl_drive_low),
        .high_start    (high_start),
        .low_start     (low_start)
    );

endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [11:0] clk_div_count = 12'd10;
    logic        fast_mode = 1'b0;
    logic        duty_16_9 = 1'b0;
    logic [5:0]  rise_count = 6'd1;
    logic        scl_in;
    logic        scl_drive_low, high_start, low_start;

    int  rise_dly = 0;
    logic stretch = 1'b0;
    int  rel_cnt = 0;
    int  total = 0;
    int  fails = 0;
    int  pulse_viol = 0;
    logic prev_ls = 1'b0, prev_hs = 1'b0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_clkgen u_dut (
        .clk           (clk),
        .rst           (rst),
        .run_en        (run_en),
        .clk_div_count (clk_div_count),
        .fast_mode     (fast_mode),
        .duty_16_9     (duty_16_9),
        .rise_count    (rise_count),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .high_start    (high_start),
        .low_start     (low_start)
    );

    // Bus model: line rises rise_dly cycles after release unless stretched.
    always_ff @(posedge clk) begin
        if (rst || scl_drive_low) rel_cnt <= 0;
        else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
    end
    assign scl_in = !stretch && !scl_drive_low && (rel_cnt >= rise_dly);

    // R9 pulse monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (low_start && high_start) pulse_viol++;
            if (low_start && prev_ls) pulse_viol++;
            if (high_start && prev_hs) pulse_viol++;
        end
        prev_ls = low_start;
        prev_hs = high_start;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input bit fm, input bit dt, input int cnt,
                           input int rc, input int dly);
        @(negedge clk);
        fast_mode     = fm;
        duty_16_9     = dt;
        clk_div_count = 12'(cnt);
        rise_count    = 6'(rc);
        rise_dly      = dly;
    endtask

    task automatic wait_low_start(input string req);
        bit seen = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (low_start) begin
                seen = 1;
                break;
            end
        end
        if (!seen) check(0, req, "low_start seen", 0, 1);
    endtask

    // Measures one period starting at a low_start pulse.
    task automatic measure(input int exp_low, input int exp_high, input string req);
        int t = 0, t_hs = -1, t_ls2 = -1, lowc = 0;
        wait_low_start(req);
        wait_low_start(req);
        if (scl_drive_low) lowc++;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            t++;
            if (scl_drive_low && t_hs < 0) lowc++;
            if (high_start) t_hs = t;
            if (low_start) begin
                t_ls2 = t;
                break;
            end
        end
        check(lowc == exp_low, req, "low phase length", lowc, exp_low);
        check((t_ls2 - t_hs) == exp_high, req, "timed high length", t_ls2 - t_hs, exp_high);
        check(t_ls2 == exp_low + rise_dly + 1 + exp_high, req, "period",
              t_ls2, exp_low + rise_dly + 1 + exp_high);
    endtask

    task automatic test_reset();
        int bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (scl_drive_low || low_start || high_start) bad++;
        end
        check(bad == 0, "R10", "outputs idle in reset", bad, 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (scl_drive_low || low_start || high_start) bad++;
        end
        check(bad == 0, "R8", "outputs idle with run_en low", bad, 0);
    endtask

    task automatic test_std();
        set_cfg(0, 0, 10, 3, 2);
        run_en = 1'b1;
        measure(10, 7, "R1");
    endtask

    task automatic test_std_floor();
        set_cfg(0, 0, 2, 1, 0);
        measure(4, 3, "R4");
    endtask

    task automatic test_fast_2to1();
        set_cfg(1, 0, 5, 2, 1);
        measure(10, 3, "R2");
    endtask

    task automatic test_fast_16to9();
        set_cfg(1, 1, 3, 4, 3);
        measure(48, 23, "R3");
    endtask

    task automatic test_fast_zero();
        set_cfg(1, 0, 0, 1, 0);
        measure(2, 1, "R5");
    endtask

    task automatic test_rise_floor();
        set_cfg(0, 0, 5, 20, 0);
        measure(5, 1, "R6");
    endtask

    task automatic test_stretch();
        int bad = 0, n = 0, m = 0;
        set_cfg(0, 0, 6, 1, 0);
        wait_low_start("R7");
        stretch = 1'b1;
        for (int i = 0; i < 100 && scl_drive_low; i++) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (high_start || scl_drive_low) bad++;
        end
        check(bad == 0, "R7", "no high_start while held low", bad, 0);
        stretch = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (high_start) break;
        end
        check(n == 1, "R7", "cycles to high_start after release", n, 1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            m++;
            if (low_start) break;
        end
        check(m == 5, "R7", "high length after stretch", m, 5);
    endtask

    task automatic test_disable();
        int bad = 0, lowc = 1;
        set_cfg(0, 0, 6, 1, 0);
        wait_low_start("R8");
        @(negedge clk);
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R8", "released after disable", scl_drive_low, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_drive_low || low_start || high_start) bad++;
        end
        check(bad == 0, "R8", "quiet while disabled", bad, 0);
        run_en = 1'b1;
        @(negedge clk);
        check(low_start && scl_drive_low, "R8", "low_start on re-enable",
              int'(low_start && scl_drive_low), 1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!scl_drive_low) break;
            lowc++;
        end
        check(lowc == 6, "R8", "full low phase after re-enable", lowc, 6);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            check(0, "WDOG", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_std();
        test_std_floor();
        test_fast_2to1();
        test_fast_16to9();
        test_fast_zero();
        test_rise_floor();
        test_stretch();
        test_disable();
        check(pulse_viol == 0, "R9", "pulse width/exclusion violations", pulse_viol, 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule